// File: doc/BRIEF.md
# SPI Master Register and Interrupt Front End

This block is the bus-facing register file of an SPI master. It sits on a 32-bit APB-style bus (two-phase access: setup with `psel`, then one access cycle with `penable`, no wait states). It stores every setting the frame engine and the clock divider need: control, frame size, a 32-bit frame count split across two offsets, clock divider value and slave select. It also carries the engine's status word onto the bus and forwards receive and transmit data accesses as one-cycle strobes.

Four event pulses come back from the engine: tx-done, rx-ready, rx overflow and tx underrun. Each pulse sets a sticky raw flag. Software clears a flag by writing 1 to it. A per-source enable taken from the control word masks the flags, and the OR of the masked flags drives one level interrupt. Several settings are frozen while the enable bit is stored as 1. Software therefore clears enable, changes the frame size or frame count, and then enables again.

Top module: `spi_regfront`

## Requirements
- R1: After reset, offset 0x00 reads 0, 0x04 reads 8, 0x50 reads 0, 0x24 reads 0 and `irq_o` is 0.
- R2: While the stored enable is 0, a write to 0x00 updates all 32 control bits, and they read back unchanged. The fields appear on the outputs: bit 0 enable, bit 1 master, bits 3:2 protocol, bits 23:8 low frame count, bit 24 polarity, bit 25 phase, bit 28 clock mode.
- R3: While the stored enable is 1, writes to the frame size (0x04) and to control bits 23:8 have no effect. The other control bits are still written.
- R4: A write to 0x50 stores only its bits 31:16, as the upper frame count, and only while enable is 0. Reading 0x50 returns {upper, lower} frame count, which is also `frame_count_o`.
- R5: Offset 0x08 returns `stat_i` in bits 14:0, with zeros above.
- R6: A pulse on `evt_i[k]` sets raw flag k, which reads at 0x24 bit k (0 tx-done, 1 rx-ready, 2 rx overflow, 3 tx underrun). Writing 1 to bit k of 0x0C clears flag k. Writing 0 to a bit leaves that flag unchanged.
- R7: If an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: Offset 0x20 returns the raw flags ANDed with their enables: tx-done with control bit 5, rx-ready with bit 4, rx overflow with bit 6, tx underrun with bit 7. `irq_o` is 1 exactly when this masked value is nonzero.
- R9: A read access to 0x10 returns `rx_data_i` and raises `rx_pop_o` for that access cycle only. A write access to 0x14 raises `tx_push_o` for that cycle, with `tx_data_o` equal to the written word. No other access raises either strobe.
- R10: 0x18 holds an 8-bit divider value on `clk_gen_o`. 0x1C holds the select bits 7:0 on `ssel_o`, bit 8 on `ssel_direct_o` and bit 9 on `ssel_oe_o`. Both read back with zeros above their fields.
- R11: Reads of 0x0C, 0x14 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| stat_i | input | 15 | Engine and FIFO status word |
| evt_i | input | 4 | Event pulses: tx-done, rx-ready, rx overflow, tx underrun |
| rx_data_i | input | 32 | Head of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 32 | Transmit word |
| cfg_enable_o | output | 1 | Core enable |
| cfg_master_o | output | 1 | Master mode |
| cfg_proto_o | output | 2 | Protocol select, 0 = Motorola |
| cfg_cpol_o | output | 1 | Clock polarity |
| cfg_cpha_o | output | 1 | Clock phase |
| cfg_hold_sel_o | output | 1 | Keep select across empty FIFO |
| cfg_frame_urun_o | output | 1 | Frame underrun mode |
| cfg_clk_mode_o | output | 1 | Divider law select |
| cfg_big_fifo_o | output | 1 | Deep FIFO mode |
| cfg_oe_off_o | output | 1 | Data output enable off |
| cfg_soft_rst_o | output | 1 | Engine reset request |
| frame_size_o | output | 6 | Bits per frame |
| frame_count_o | output | 32 | Frames per transfer |
| clk_gen_o | output | 8 | Divider value |
| ssel_o | output | 8 | Per-device select bits |
| ssel_direct_o | output | 1 | Software-driven select |
| ssel_oe_o | output | 1 | Select output enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The interrupt logic is driven with single event pulses, multi-bit pulses, clears of only some bits, and an event that lands in the same cycle as its own clear. These patterns separate sticky set, selective clear and the event-wins rule. The mask is exercised one enable at a time, against flags both inside and outside that enable, so a swapped enable-to-source mapping shows up. The frame settings are written before enable, while enabled and after disable. This shows whether the freeze uses the stored enable bit or the enable bit in the incoming write.

// File: rtl/spi_rf_pkg.sv
// Shared offsets, field layout and event indices for the SPI register front end.
// Assumes a byte-addressed bus with word-aligned accesses.
package spi_rf_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_FSIZE  = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h08;
    localparam logic [7:0] OFS_CLR    = 8'h0C;
    localparam logic [7:0] OFS_RXD    = 8'h10;
    localparam logic [7:0] OFS_TXD    = 8'h14;
    localparam logic [7:0] OFS_CLKG   = 8'h18;
    localparam logic [7:0] OFS_SSEL   = 8'h1C;
    localparam logic [7:0] OFS_MIS    = 8'h20;
    localparam logic [7:0] OFS_RIS    = 8'h24;
    localparam logic [7:0] OFS_CNTHI  = 8'h50;

    // Event indices (bit positions in raw and masked status)
    localparam int EV_TXDONE = 0;
    localparam int EV_RXRDY  = 1;
    localparam int EV_RXOVF  = 2;
    localparam int EV_TXURUN = 3;
    localparam int NEV       = 4;

    // Interrupt-enable indices inside the control word's enable nibble
    localparam int IE_RXDATA = 0;
    localparam int IE_TXDATA = 1;
    localparam int IE_RXOVF  = 2;
    localparam int IE_TXURUN = 3;

    // Control word, MSB first
    typedef struct packed {
        logic        soft_rst;
        logic        oe_off;
        logic        big_fifo;
        logic        clk_mode;
        logic        frame_urun;
        logic        hold_sel;
        logic        cpha;
        logic        cpol;
        logic [15:0] cnt_lo;
        logic [3:0]  ie;
        logic [1:0]  proto;
        logic        master;
        logic        enable;
    } ctrl_t;
endpackage

// File: rtl/spi_rf_cfg.sv
// Configuration storage: control word, frame size, upper frame count,
// divider value and slave select. Frame size and both frame-count halves
// are frozen while the stored enable bit is 1.
module spi_rf_cfg
    import spi_rf_pkg::*;
#(
    parameter int FSIZE_W   = 6,
    parameter int FSIZE_RST = 8,
    parameter int CLKDIV_W  = 8,
    parameter int NSEL      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_ctrl,
    input  logic                we_fsize,
    input  logic                we_cnthi,
    input  logic                we_clkg,
    input  logic                we_ssel,
    input  logic [31:0]         wdata,
    output ctrl_t               ctrl_o,
    output logic [FSIZE_W-1:0]  fsize_o,
    output logic [15:0]         cnt_hi_o,
    output logic [CLKDIV_W-1:0] clkg_o,
    output logic [NSEL-1:0]     sel_o,
    output logic                sel_dir_o,
    output logic                sel_oe_o
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_wr;

    // Merge a control write: the count field is kept while enabled
    always_comb begin
        ctrl_wr = ctrl_t'(wdata);
        if (ctrl_q.enable) ctrl_wr.cnt_lo = ctrl_q.cnt_lo;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (we_ctrl) ctrl_q <= ctrl_wr;
    end

    // Frame size and upper frame count, both gated by the stored enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsize_o  <= FSIZE_W'(FSIZE_RST);
            cnt_hi_o <= '0;
        end else if (!ctrl_q.enable) begin
            if (we_fsize) fsize_o  <= wdata[FSIZE_W-1:0];
            if (we_cnthi) cnt_hi_o <= wdata[31:16];
        end
    end

    // Divider and slave select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkg_o    <= '0;
            sel_o     <= '0;
            sel_dir_o <= 1'b0;
            sel_oe_o  <= 1'b0;
        end else begin
            if (we_clkg) clkg_o <= wdata[CLKDIV_W-1:0];
            if (we_ssel) begin
                sel_o     <= wdata[NSEL-1:0];
                sel_dir_o <= wdata[8];
                sel_oe_o  <= wdata[9];
            end
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/spi_rf_irq.sv
// Sticky raw event flags with write-1-to-clear, source masking and the
// level interrupt. A new event beats a clear of the same flag.
module spi_rf_irq
    import spi_rf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] evt_i,
    input  logic           clr_we,
    input  logic [NEV-1:0] clr_bits,
    input  logic [3:0]     ie_i,
    output logic [NEV-1:0] raw_o,
    output logic [NEV-1:0] mis_o,
    output logic           irq_o
);
    logic [NEV-1:0] raw_q;
    logic [NEV-1:0] mask;
    logic [NEV-1:0] clr_eff;

    // Map each event to the enable bit that covers it
    always_comb begin
        mask            = '0;
        mask[EV_TXDONE] = ie_i[IE_TXDATA];
        mask[EV_RXRDY]  = ie_i[IE_RXDATA];
        mask[EV_RXOVF]  = ie_i[IE_RXOVF];
        mask[EV_TXURUN] = ie_i[IE_TXURUN];
    end

    assign clr_eff = clr_we ? clr_bits : '0;

    // Raw flags: clear first, then set by events so events take priority
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_eff) | evt_i;
    end

    assign raw_o = raw_q;
    assign mis_o = raw_q & mask;
    assign irq_o = |mis_o;
endmodule

// File: rtl/spi_regfront.sv
// Top of the SPI register front end. Decodes bus accesses, instantiates
// configuration storage and interrupt logic, and builds the read mux.
// Assumes a zero-wait-state bus: the access phase lasts one cycle.
module spi_regfront
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int FSIZE_W   = 6,
    parameter int FSIZE_RST = 8,
    parameter int CLKDIV_W  = 8,
    parameter int NSEL      = 8,
    parameter int STAT_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    input  logic [STAT_W-1:0]   stat_i,
    input  logic [3:0]          evt_i,
    input  logic [31:0]         rx_data_i,
    output logic                rx_pop_o,
    output logic                tx_push_o,
    output logic [31:0]         tx_data_o,
    output logic                cfg_enable_o,
    output logic                cfg_master_o,
    output logic [1:0]          cfg_proto_o,
    output logic                cfg_cpol_o,
    output logic                cfg_cpha_o,
    output logic                cfg_hold_sel_o,
    output logic                cfg_frame_urun_o,
    output logic                cfg_clk_mode_o,
    output logic                cfg_big_fifo_o,
    output logic                cfg_oe_off_o,
    output logic                cfg_soft_rst_o,
    output logic [FSIZE_W-1:0]  frame_size_o,
    output logic [31:0]         frame_count_o,
    output logic [CLKDIV_W-1:0] clk_gen_o,
    output logic [NSEL-1:0]     ssel_o,
    output logic                ssel_direct_o,
    output logic                ssel_oe_o,
    output logic                irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_FSIZE = ADDR_W'(OFS_FSIZE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFS_RXD);
    localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFS_TXD);
    localparam logic [ADDR_W-1:0] A_CLKG  = ADDR_W'(OFS_CLKG);
    localparam logic [ADDR_W-1:0] A_SSEL  = ADDR_W'(OFS_SSEL);
    localparam logic [ADDR_W-1:0] A_MIS   = ADDR_W'(OFS_MIS);
    localparam logic [ADDR_W-1:0] A_RIS   = ADDR_W'(OFS_RIS);
    localparam logic [ADDR_W-1:0] A_CNTHI = ADDR_W'(OFS_CNTHI);

    logic           acc_wr;
    logic           acc_rd;
    ctrl_t          ctrl;
    logic [15:0]    cnt_hi;
    logic [NEV-1:0] raw_q;
    logic [NEV-1:0] mis;
    logic [31:0]    ssel_rd;

    assign acc_wr = psel & penable & pwrite;
    assign acc_rd = psel & penable & ~pwrite;

    spi_rf_cfg #(
        .FSIZE_W  (FSIZE_W),
        .FSIZE_RST(FSIZE_RST),
        .CLKDIV_W (CLKDIV_W),
        .NSEL     (NSEL)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_ctrl  (acc_wr && paddr == A_CTRL),
        .we_fsize (acc_wr && paddr == A_FSIZE),
        .we_cnthi (acc_wr && paddr == A_CNTHI),
        .we_clkg  (acc_wr && paddr == A_CLKG),
        .we_ssel  (acc_wr && paddr == A_SSEL),
        .wdata    (pwdata),
        .ctrl_o   (ctrl),
        .fsize_o  (frame_size_o),
        .cnt_hi_o (cnt_hi),
        .clkg_o   (clk_gen_o),
        .sel_o    (ssel_o),
        .sel_dir_o(ssel_direct_o),
        .sel_oe_o (ssel_oe_o)
    );

    spi_rf_irq irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_we  (acc_wr && paddr == A_CLR),
        .clr_bits(pwdata[NEV-1:0]),
        .ie_i    (ctrl.ie),
        .raw_o   (raw_q),
        .mis_o   (mis),
        .irq_o   (irq_o)
    );

    // Data port strobes, valid during the single access cycle
    assign rx_pop_o  = acc_rd && paddr == A_RXD;
    assign tx_push_o = acc_wr && paddr == A_TXD;
    assign tx_data_o = pwdata;

    // Slave select readback with fixed positions for direct and output enable
    always_comb begin
        ssel_rd         = '0;
        ssel_rd[NSEL-1:0] = ssel_o;
        ssel_rd[8]      = ssel_direct_o;
        ssel_rd[9]      = ssel_oe_o;
    end

    // Read data mux
    always_comb begin
        case (paddr)
            A_CTRL:  prdata = ctrl;
            A_FSIZE: prdata = 32'(frame_size_o);
            A_STAT:  prdata = 32'(stat_i);
            A_RXD:   prdata = rx_data_i;
            A_CLKG:  prdata = 32'(clk_gen_o);
            A_SSEL:  prdata = ssel_rd;
            A_MIS:   prdata = 32'(mis);
            A_RIS:   prdata = 32'(raw_q);
            A_CNTHI: prdata = {cnt_hi, ctrl.cnt_lo};
            default: prdata = '0;
        endcase
    end

    assign frame_count_o    = {cnt_hi, ctrl.cnt_lo};
    assign cfg_enable_o     = ctrl.enable;
    assign cfg_master_o     = ctrl.master;
    assign cfg_proto_o      = ctrl.proto;
    assign cfg_cpol_o       = ctrl.cpol;
    assign cfg_cpha_o       = ctrl.cpha;
    assign cfg_hold_sel_o   = ctrl.hold_sel;
    assign cfg_frame_urun_o = ctrl.frame_urun;
    assign cfg_clk_mode_o   = ctrl.clk_mode;
    assign cfg_big_fifo_o   = ctrl.big_fifo;
    assign cfg_oe_off_o     = ctrl.oe_off;
    assign cfg_soft_rst_o   = ctrl.soft_rst;
endmodule

// File: rtl/spi_rf_chk.sv
// Protocol and state checks for the SPI register front end, bound to the top.
module spi_rf_chk
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int FSIZE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [3:0]         clr_data,
    input logic [3:0]         evt_i,
    input logic [3:0]         raw,
    input logic               irq_o,
    input logic               cfg_enable_o,
    input logic [FSIZE_W-1:0] frame_size_o,
    input logic [31:0]        frame_count_o,
    input logic               rx_pop_o,
    input logic               tx_push_o
);
    logic clr_acc;
    assign clr_acc = psel && penable && pwrite && paddr == ADDR_W'(OFS_CLR);

    // R6
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != 4'h0) |=> ((raw & $past(evt_i)) == $past(evt_i)));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_acc && evt_i == 4'h0) |=> ((raw & $past(clr_data)) == 4'h0));

    // R7
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_acc && (evt_i & clr_data) != 4'h0)
        |=> ((raw & $past(evt_i & clr_data)) == $past(evt_i & clr_data)));

    // R8
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw != 4'h0));

    // R3
    frozen_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable_o |=> ($stable(frame_size_o) && $stable(frame_count_o)));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push_o, rx_pop_o}));

    // R9
    pop_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> (psel && penable && !pwrite));
endmodule

bind spi_regfront spi_rf_chk #(.ADDR_W(ADDR_W), .FSIZE_W(FSIZE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .clr_data     (pwdata[3:0]),
    .evt_i        (evt_i),
    .raw          (raw_q),
    .irq_o        (irq_o),
    .cfg_enable_o (cfg_enable_o),
    .frame_size_o (frame_size_o),
    .frame_count_o(frame_count_o),
    .rx_pop_o     (rx_pop_o),
    .tx_push_o    (tx_push_o)
);

// File: tb/spi_regfront_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a negedge monitor
// compares them and the data-port strobes during each access cycle.
module spi_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [14:0] stat_i = '0;
    logic [3:0]  evt_i = '0;
    logic [31:0] rx_data_i = '0;
    logic        rx_pop_o, tx_push_o;
    logic [31:0] tx_data_o;
    logic        cfg_enable_o, cfg_master_o, cfg_cpol_o, cfg_cpha_o;
    logic        cfg_hold_sel_o, cfg_frame_urun_o, cfg_clk_mode_o;
    logic        cfg_big_fifo_o, cfg_oe_off_o, cfg_soft_rst_o;
    logic [1:0]  cfg_proto_o;
    logic [5:0]  frame_size_o;
    logic [31:0] frame_count_o;
    logic [7:0]  clk_gen_o, ssel_o;
    logic        ssel_direct_o, ssel_oe_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    spi_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .stat_i(stat_i), .evt_i(evt_i), .rx_data_i(rx_data_i),
        .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .tx_data_o(tx_data_o),
        .cfg_enable_o(cfg_enable_o), .cfg_master_o(cfg_master_o),
        .cfg_proto_o(cfg_proto_o), .cfg_cpol_o(cfg_cpol_o),
        .cfg_cpha_o(cfg_cpha_o), .cfg_hold_sel_o(cfg_hold_sel_o),
        .cfg_frame_urun_o(cfg_frame_urun_o), .cfg_clk_mode_o(cfg_clk_mode_o),
        .cfg_big_fifo_o(cfg_big_fifo_o), .cfg_oe_off_o(cfg_oe_off_o),
        .cfg_soft_rst_o(cfg_soft_rst_o), .frame_size_o(frame_size_o),
        .frame_count_o(frame_count_o), .clk_gen_o(clk_gen_o),
        .ssel_o(ssel_o), .ssel_direct_o(ssel_direct_o),
        .ssel_oe_o(ssel_oe_o), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] ev = 4'h0);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1; evt_i = ev;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; evt_i = 4'h0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(logic [3:0] ev);
        @(posedge clk); #1; evt_i = ev;
        @(posedge clk); #1; evt_i = 4'h0;
    endtask

    task automatic peek(string tag, logic [31:0] act_now, logic [31:0] exp);
        check(tag, act_now, exp);
    endtask

    // Monitor: compare read data and data-port strobes in each access cycle
    always @(negedge clk) begin
        if (rst_n && psel && penable) begin
            if (!pwrite) begin
                if (sb_q.size() == 0) begin
                    check("R9 unexpected read", 32'h1, 32'h0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(it.tag, prdata, it.exp);
                end
                check("R9 rx_pop level", {31'b0, rx_pop_o}, {31'b0, paddr == 8'h10});
                check("R9 no push on read", {31'b0, tx_push_o}, 32'h0);
            end else begin
                check("R9 tx_push level", {31'b0, tx_push_o}, {31'b0, paddr == 8'h14});
                check("R9 no pop on write", {31'b0, rx_pop_o}, 32'h0);
                if (paddr == 8'h14) check("R9 tx_data", tx_data_o, pwdata);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 ctrl reset");
        rd(8'h04, 32'h8, "R1 fsize reset");
        rd(8'h50, 32'h0, "R1 count reset");
        rd(8'h24, 32'h0, "R1 raw reset");
        @(negedge clk); peek("R1 irq reset", {31'b0, irq_o}, 32'h0);

        // R2 control write while disabled
        wr(8'h00, 32'h5A12_3456);
        rd(8'h00, 32'h5A12_3456, "R2 ctrl readback");
        @(negedge clk);
        peek("R2 fields", {24'b0, cfg_cpol_o, cfg_cpha_o, cfg_clk_mode_o,
              cfg_master_o, cfg_enable_o, 1'b0, cfg_proto_o},
             {24'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01});
        peek("R2 count low", frame_count_o, 32'h0000_1234);

        // R4 upper count via its own offset
        wr(8'h50, 32'hBEEF_1111);
        rd(8'h50, 32'hBEEF_1234, "R4 count readback");
        wr(8'h04, 32'h20);
        rd(8'h04, 32'h20, "R3 fsize written when disabled");

        // Enable, then try frozen fields
        wr(8'h00, 32'h00FF_FF01);
        rd(8'h00, 32'h00FF_FF01, "R2 count taken with enable write");
        wr(8'h00, 32'h0100_0001);
        rd(8'h00, 32'h01FF_FF01, "R3 count frozen, polarity written");
        wr(8'h04, 32'h10);
        rd(8'h04, 32'h20, "R3 fsize frozen");
        wr(8'h50, 32'h0000_0000);
        rd(8'h50, 32'hBEEF_FFFF, "R4 upper frozen");
        @(negedge clk); peek("R4 frame_count_o", frame_count_o, 32'hBEEF_FFFF);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, 32'h00FF_FF00, "R3 disabling write keeps count");
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, 32'h0, "R2 count clears once disabled");

        // R5 status passthrough
        stat_i = 15'h5A5A;
        rd(8'h08, 32'h5A5A, "R5 status pattern");
        stat_i = 15'h7FFF;
        rd(8'h08, 32'h7FFF, "R5 status all ones");

        // R6 R8 raw latch, masking and W1C
        pulse(4'b0101);
        rd(8'h24, 32'h5, "R6 raw latch");
        rd(8'h20, 32'h0, "R8 masked all off");
        @(negedge clk); peek("R8 irq low", {31'b0, irq_o}, 32'h0);
        wr(8'h0C, 32'h1);
        rd(8'h24, 32'h4, "R6 partial clear");
        wr(8'h00, 32'h40);
        rd(8'h20, 32'h4, "R8 overflow enable");
        @(negedge clk); peek("R8 irq high", {31'b0, irq_o}, 32'h1);

        // R7 event in same cycle as its clear
        wr(8'h0C, 32'h4, 4'b0100);
        rd(8'h24, 32'h4, "R7 event wins over clear");
        wr(8'h0C, 32'h4);
        rd(8'h24, 32'h0, "R6 clear after event");
        @(negedge clk); peek("R8 irq drops", {31'b0, irq_o}, 32'h0);

        // R8 enable-to-source mapping
        wr(8'h00, 32'h20);
        pulse(4'b0010);
        rd(8'h20, 32'h0, "R8 rx-ready not under tx enable");
        @(negedge clk); peek("R8 irq off for rx-ready", {31'b0, irq_o}, 32'h0);
        pulse(4'b0001);
        rd(8'h20, 32'h1, "R8 tx-done under tx enable");
        wr(8'h00, 32'h10);
        rd(8'h20, 32'h2, "R8 rx-ready under rx enable");
        wr(8'h00, 32'h80);
        rd(8'h20, 32'h0, "R8 underrun enable alone");
        pulse(4'b1000);
        rd(8'h20, 32'h8, "R8 underrun flagged");
        wr(8'h0C, 32'hF);
        rd(8'h24, 32'h0, "R6 clear all");

        // R11 write-only and unmapped offsets
        rd(8'h0C, 32'h0, "R11 clear offset reads zero");
        rd(8'h3C, 32'h0, "R11 unmapped reads zero");
        rd(8'h14, 32'h0, "R11 tx port reads zero");

        // R9 data ports
        rx_data_i = 32'hC3C3_00C3;
        rd(8'h10, 32'hC3C3_00C3, "R9 rx data");
        wr(8'h14, 32'hA5A5_0101);

        // R10 divider and slave select
        wr(8'h18, 32'h1FF);
        rd(8'h18, 32'hFF, "R10 divider readback");
        @(negedge clk); peek("R10 clk_gen_o", {24'b0, clk_gen_o}, 32'hFF);
        wr(8'h1C, 32'hFFFF_F3A5);
        rd(8'h1C, 32'h3A5, "R10 select readback");
        @(negedge clk);
        peek("R10 select outputs", {22'b0, ssel_oe_o, ssel_direct_o, ssel_o},
             32'h3A5);

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) check("scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule